// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the clock and data lines of a two-wire SMBus/I2C port, already synchronised to the kernel clock. It raises one sticky timeout flag when one of three conditions lasts past a programmed limit. The first is the clock line held low without a break. The second is the bus sitting idle, with both lines high. The third is this interface's own clock stretching, added up across a transfer. The protocol engine beside it supplies a "stretching now" indication and one-cycle START and STOP detection pulses. Software clears the flag with a pulse on `clear_i`.

A 32-bit control word sets the behaviour. It holds two 12-bit limits, an enable for each time base, and a selector that points the shared limit at either the clock-low detector or the bus-idle detector. Writes enter through a valid/ready channel. Each accepted write takes `WR_LAT` cycles to commit, and `wr_ready_o` stays low during that time. A producer that holds `wr_valid_i` high with stable data is back-pressured until the earlier write has finished. Limit fields cannot be changed while the detector that uses them is enabled.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset the control word reads 0, `timeout_o` is 0 and `wr_ready_o` is 1.
- R2: A write is taken on a clock edge where `wr_valid_i` and `wr_ready_o` are both 1. `wr_ready_o` is then 0 for `WR_LAT` (default 3) cycles. The new value appears on `ctrl_o` after the edge `WR_LAT` cycles past acceptance. A write offered meanwhile waits with its valid held.
- R3: Control word fields: bit 31 = extended (stretch) enable, bits 27:16 = limit B, bit 15 = clock timeout enable, bit 12 = idle select, bits 11:0 = limit A. Bits 30:28 and 14:13 always read 0.
- R4: A committed write leaves limit A and the idle select unchanged if bit 15 was 1 before the commit.
- R5: A committed write leaves limit B unchanged if bit 31 was 1 before the commit.
- R6: With bit 15 = 1 and bit 12 = 0, `timeout_o` rises after the edge on which `scl_i` has been sampled low on (A+1)×2048 consecutive edges.
- R7: A clock-low or idle run restarts from zero whenever its condition breaks for one edge.
- R8: With bit 15 = 1 and bit 12 = 1, `timeout_o` rises after the edge on which `scl_i` and `sda_i` have both been sampled high on (A+1)×4 consecutive edges.
- R9: With bit 31 = 1, edges with `stretch_i` = 1 add up. Edges without it pause the total. `start_i` or `stop_i` reset the total to zero. `timeout_o` rises when the total reaches (B+1)×2048.
- R10: `timeout_o` stays 1 until an edge with `clear_i` = 1. A detection on that same edge wins, and the flag stays 1.
- R11: A detector counts only while its enable is 1, and clearing the enable resets it. Each unbroken run raises the flag at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Control write offered |
| wr_ready_o | output | 1 | Write channel free |
| wr_data_i | input | 32 | Control word to write |
| ctrl_o | output | 32 | Current control word |
| scl_i | input | 1 | Synchronised clock line level |
| sda_i | input | 1 | Synchronised data line level |
| stretch_i | input | 1 | This interface is holding the clock low |
| start_i | input | 1 | START detected (one-cycle pulse) |
| stop_i | input | 1 | STOP detected (one-cycle pulse) |
| clear_i | input | 1 | Clears the timeout flag |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
Two events can land on the same edge. A detector can expire on the edge where software pulses `clear_i`, and a control write can commit on the edge where a detector is counting. The bench holds `clear_i` high through a whole idle run, so the expiry edge and the clear coincide. It then expects the flag to be 1 after that edge and 0 one edge later, with no second expiry. For the commit collision, the bench disables the clock-low detector partway through a run. The counter must restart from the commit edge, so the expiry falls a full period after the detector is enabled again. A behavioural model judges both cases on every cycle.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int LIM_W     = 12;
  localparam int BIT_EXT   = 31;
  localparam int B_LO      = 16;
  localparam int BIT_CLK   = 15;
  localparam int BIT_IDLE  = 12;
  localparam int A_LO      = 0;

  typedef struct packed {
    logic             ext_en;
    logic [LIM_W-1:0] lim_b;
    logic             clk_en;
    logic             idle_sel;
    logic [LIM_W-1:0] lim_a;
  } tmo_cfg_t;

  function automatic logic [31:0] cfg_to_word(tmo_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_EXT]               = c.ext_en;
    w[B_LO +: LIM_W]         = c.lim_b;
    w[BIT_CLK]               = c.clk_en;
    w[BIT_IDLE]              = c.idle_sel;
    w[A_LO +: LIM_W]         = c.lim_a;
    return w;
  endfunction
endpackage

// File: rtl/tmo_ctrl_reg.sv
module tmo_ctrl_reg
  import tmo_pkg::*;
#(
  parameter int WR_LAT = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  input  logic [31:0] wr_data_i,
  output tmo_cfg_t    cfg_o
);
  localparam int WAIT_W = $clog2(WR_LAT + 1);

  logic [WAIT_W-1:0] wait_q;
  logic [31:0]       pend_q;
  tmo_cfg_t          cfg_q;
  tmo_cfg_t          cfg_nxt;
  logic              commit;

  assign wr_ready_o = (wait_q == '0);
  assign commit     = (wait_q == WAIT_W'(1));

  // Lock rules look at the enables held before this commit
  always_comb begin
    cfg_nxt        = cfg_q;
    cfg_nxt.ext_en = pend_q[BIT_EXT];
    cfg_nxt.clk_en = pend_q[BIT_CLK];
    if (!cfg_q.ext_en) cfg_nxt.lim_b = pend_q[B_LO +: LIM_W];
    if (!cfg_q.clk_en) begin
      cfg_nxt.idle_sel = pend_q[BIT_IDLE];
      cfg_nxt.lim_a    = pend_q[A_LO +: LIM_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      pend_q <= '0;
      cfg_q  <= '0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - WAIT_W'(1);
      if (commit) cfg_q <= cfg_nxt;
    end else if (wr_valid_i) begin
      pend_q <= wr_data_i;
      wait_q <= WAIT_W'(WR_LAT);
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tmo_span_counter.sv
module tmo_span_counter #(
  parameter int LIM_W = 12,
  parameter int SHIFT = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             advance_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             hit_o
);
  localparam int TW = LIM_W + 1;

  logic [SHIFT-1:0] pre_q;
  logic [TW-1:0]    tick_q;
  logic [TW-1:0]    target;
  logic             reached;
  logic             adv_eff;
  logic             pre_max;

  assign target  = TW'(limit_i) + TW'(1);
  assign reached = (tick_q == target);
  assign adv_eff = advance_i && !reached;
  assign pre_max = &pre_q;
  assign hit_o   = !restart_i && adv_eff && pre_max && (tick_q == target - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (restart_i) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (adv_eff) begin
      pre_q <= pre_q + SHIFT'(1);
      if (pre_max) tick_q <= tick_q + TW'(1);
    end
  end
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
  import tmo_pkg::*;
#(
  parameter int WR_LAT     = 3,
  parameter int LONG_SHIFT = 11,
  parameter int IDLE_SHIFT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        stretch_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        clear_i,
  output logic        timeout_o
);
  localparam int NDET = 3;

  tmo_cfg_t              cfg;
  logic [NDET-1:0]       run, restart, advance, hit;
  logic [NDET-1:0][LIM_W-1:0] limit;
  logic                  flag_q;

  tmo_ctrl_reg #(.WR_LAT(WR_LAT)) u_reg (
    .clk_i, .rst_ni, .wr_valid_i, .wr_ready_o, .wr_data_i, .cfg_o(cfg)
  );

  // 0: clock low, 1: bus idle, 2: cumulative stretch
  assign run[0]     = cfg.clk_en && !cfg.idle_sel && !scl_i;
  assign run[1]     = cfg.clk_en &&  cfg.idle_sel && scl_i && sda_i;
  assign restart[0] = !run[0];
  assign restart[1] = !run[1];
  assign advance[0] = run[0];
  assign advance[1] = run[1];
  assign run[2]     = cfg.ext_en;
  assign restart[2] = !cfg.ext_en || start_i || stop_i;
  assign advance[2] = stretch_i;
  assign limit[0]   = cfg.lim_a;
  assign limit[1]   = cfg.lim_a;
  assign limit[2]   = cfg.lim_b;

  for (genvar d = 0; d < NDET; d++) begin : g_det
    localparam int SH = (d == 1) ? IDLE_SHIFT : LONG_SHIFT;
    tmo_span_counter #(.LIM_W(LIM_W), .SHIFT(SH)) u_cnt (
      .clk_i, .rst_ni,
      .restart_i(restart[d]),
      .advance_i(advance[d]),
      .limit_i(limit[d]),
      .hit_o(hit[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (|hit)    flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end

  assign timeout_o = flag_q;
  assign ctrl_o    = cfg_to_word(cfg);
endmodule

// File: rtl/tmo_checker.sv
module tmo_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_valid_i,
  input logic        wr_ready_o,
  input logic [31:0] ctrl_o,
  input logic        clear_i,
  input logic        timeout_o
);
  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o) |=> !wr_ready_o);

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[30:28] == 3'b0) && (ctrl_o[14:13] == 2'b0));

  assert_lock_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[15] |=> (ctrl_o[12:0] == $past(ctrl_o[12:0])));

  assert_lock_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[31] |=> (ctrl_o[27:16] == $past(ctrl_o[27:16])));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clear_i) |=> timeout_o);

  assert_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(ctrl_o[15] || ctrl_o[31]));
endmodule

bind smbus_timeout_mon tmo_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .ctrl_o(ctrl_o), .clear_i(clear_i), .timeout_o(timeout_o)
);

// File: tb/smbus_timeout_mon_tb.sv
module smbus_timeout_mon_tb;
  localparam int WR_LAT = 3;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready;
  logic [31:0] wr_data = '0, ctrl;
  logic scl = 1, sda = 1, stretch = 0, start = 0, stop = 0, clear = 0, tmo;

  int total = 0, bad = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  smbus_timeout_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .scl_i(scl), .sda_i(sda),
    .stretch_i(stretch), .start_i(start), .stop_i(stop), .clear_i(clear),
    .timeout_o(tmo)
  );

  // behavioural reference model
  int m_wait, low_n, idle_n, ext_n;
  logic [31:0] m_pend;
  logic m_ext, m_clk, m_idle, m_flag;
  logic [11:0] m_a, m_b;

  function automatic logic [31:0] m_word();
    return {m_ext, 3'b0, m_b, m_clk, 2'b0, m_idle, m_a};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_pend = 0; m_ext = 0; m_clk = 0; m_idle = 0; m_a = 0; m_b = 0;
      m_flag = 0; low_n = 0; idle_n = 0; ext_n = 0;
    end else begin
      automatic bit hit = 0;
      if (m_clk && !m_idle && !scl) begin
        low_n++; if (low_n == (int'(m_a) + 1) * 2048) hit = 1;
      end else low_n = 0;
      if (m_clk && m_idle && scl && sda) begin
        idle_n++; if (idle_n == (int'(m_a) + 1) * 4) hit = 1;
      end else idle_n = 0;
      if (!m_ext || start || stop) ext_n = 0;
      else if (stretch) begin
        ext_n++; if (ext_n == (int'(m_b) + 1) * 2048) hit = 1;
      end
      if (hit) m_flag = 1; else if (clear) m_flag = 0;
      if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) begin
          if (!m_clk) begin m_a = m_pend[11:0]; m_idle = m_pend[12]; end
          if (!m_ext) m_b = m_pend[27:16];
          m_clk = m_pend[15]; m_ext = m_pend[31];
        end
      end else if (wr_valid) begin
        m_pend = wr_data; m_wait = WR_LAT;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(ctrl == m_word(), "R3", ctrl, m_word());
    check(wr_ready == (m_wait == 0), "R2", wr_ready, m_wait == 0);
    check(tmo == m_flag, tag, tmo, m_flag);
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1; @(negedge clk); clear = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check(ctrl == 0 && !tmo && wr_ready, "R1", {ctrl, tmo, wr_ready}, 1);
    rst_n = 1;

    // R2: back-to-back writes, second one back-pressured
    tag = "R2";
    wr(32'h7000_6000 | 32'h0000_0005);
    check(!wr_ready, "R2", wr_ready, 0);
    wr(32'h0000_8000);            // clk_en=1, A=0, idle_sel=0
    idle_cycles(WR_LAT + 1);
    check(ctrl == 32'h0000_8000, "R3", ctrl, 32'h0000_8000);

    // R4: A and idle select locked while clk_en
    tag = "R4";
    wr(32'h0000_9007);
    idle_cycles(WR_LAT + 1);
    check(ctrl[12:0] == 0 && ctrl[15], "R4", ctrl, 32'h0000_8000);

    // R7 then R6: broken run, then a full run
    tag = "R7";
    scl = 0; idle_cycles(1500); scl = 1; @(negedge clk); scl = 0;
    idle_cycles(2000);
    check(!tmo, "R7", tmo, 0);
    tag = "R6";
    idle_cycles(60);
    check(tmo, "R6", tmo, 1);
    scl = 1; do_clear();
    check(!tmo, "R10", tmo, 0);

    // R11: disable mid-run restarts the counter
    tag = "R11";
    scl = 0; idle_cycles(1500);
    wr(32'h0);
    wr(32'h0000_8000);
    idle_cycles(1900);
    check(!tmo, "R11", tmo, 0);
    idle_cycles(200);
    check(tmo, "R11", tmo, 1);
    scl = 1; do_clear();

    // R8: idle detection with A=1 -> 8 cycles; sda break first
    tag = "R8";
    scl = 0; sda = 0;
    wr(32'h0);
    wr(32'h0000_9001);
    idle_cycles(WR_LAT + 1);
    check(ctrl == 32'h0000_9001, "R8", ctrl, 32'h0000_9001);
    scl = 1; sda = 1; idle_cycles(5); sda = 0; @(negedge clk); sda = 1;
    idle_cycles(6);
    check(!tmo, "R7", tmo, 0);
    idle_cycles(4);
    check(tmo, "R8", tmo, 1);

    // R10: clear held through a new run: expiry on a clear edge wins
    tag = "R10";
    sda = 0; clear = 1; @(negedge clk);
    check(!tmo, "R10", tmo, 0);
    sda = 1; idle_cycles(8);
    check(tmo, "R10", tmo, 1);
    @(negedge clk);
    check(!tmo, "R11", tmo, 0);
    idle_cycles(20);
    clear = 0; sda = 0;

    // R9: cumulative stretch with START clearing, B locked
    tag = "R9";
    wr(32'h8000_9001);            // ext_en=1, B=0
    wr(32'h8003_9001);            // B write ignored
    idle_cycles(WR_LAT + 1);
    check(ctrl[27:16] == 0, "R5", ctrl[27:16], 0);
    stretch = 1; idle_cycles(1500); stretch = 0;
    start = 1; @(negedge clk); start = 0;
    stretch = 1; idle_cycles(1500); stretch = 0; idle_cycles(300);
    check(!tmo, "R9", tmo, 0);
    stretch = 1; idle_cycles(540);
    check(!tmo, "R9", tmo, 0);
    idle_cycles(10);
    check(tmo, "R9", tmo, 1);
    stretch = 0; stop = 1; @(negedge clk); stop = 0;
    do_clear();
    check(!tmo, "R10", tmo, 0);

    idle_cycles(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule